// File: doc/BRIEF.md
# XOR-Coded Dual-Read Single-Write Memory

This block is a memory with two read ports and one write port, built only from single-port synchronous banks. Storage is split into three equal banks, each half the total word count: a low-half data bank, a high-half data bank and a parity bank. Every parity row holds the XOR of the matching rows of the two data banks. With that redundancy, two reads can be served in the same cycle even when both target the same single-port data bank. One port reads its word directly. The other port rebuilds its word from the opposite data bank and the parity bank.

The read-write port has an address, an active-low select, a write enable, a write data bus and output `q1`. The read-only port has its own address, a read enable and output `q2`. In any cycle the block does either a read on one or both ports or a single write.

A write takes two cycles. In the request cycle (state `ST_IDLE`) the partner data bank is read at the target row, and the FSM moves to `ST_WR_MERGE`. In `ST_WR_MERGE` the new word is stored in the target bank and its XOR with the partner word is stored in the parity bank. `busy` is high during `ST_WR_MERGE`, and the FSM always returns to `ST_IDLE` on the next edge.

Top module: `xor2r1w_mem`

## Requirements
- R1: After reset, `q1`, `q2` and `busy` are 0, and any address that has not been written reads as 0.
- R2: Address bit ADDR_W-1 selects the data bank (0 = low bank, 1 = high bank) and the lower bits select the row. Two addresses that differ only in that bit hold independent words.
- R3: A read requested in a cycle with `busy` low presents its word on the output one clock edge later. On the read-write port a read is `cs_n`=0 with `we`=0. On the read-only port a read is `rd_en`=1.
- R4: When the two ports read addresses in different data banks, both outputs return the last word written to their own addresses.
- R5: When both ports read the same data bank, both outputs still return the correct words. This includes both ports reading the same address.
- R6: A write request (`cs_n`=0, `we`=1) accepted with `busy` low raises `busy` for exactly the next cycle. Every request made while `busy` is high is ignored, and the data of any such write is never stored.
- R7: In a write cycle `rd_en` is ignored. `q1` and `q2` keep their values through the request cycle and the busy cycle.
- R8: An output whose port made no read in the previous cycle keeps its value.
- R9: Back-to-back writes to the same row in both data banks, and a later rewrite of one of them, leave the parity consistent. Same-bank dual reads of that row return the newest words.
- R10: A read issued in the first cycle after `busy` falls returns the newly written word.
- R11: With `cs_n` high, the read-only port still reads on its own and `q1` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select of the read-write port |
| we | input | 1 | Write enable of the read-write port (1 = write, 0 = read) |
| rw_addr | input | ADDR_W | Address of the read-write port |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable of the read-only port |
| ro_addr | input | ADDR_W | Address of the read-only port |
| q1 | output | DATA_W | Read data of the read-write port |
| q2 | output | DATA_W | Read data of the read-only port |
| busy | output | 1 | High in the merge cycle of a write; requests are ignored |

## Verification
The assertions check on every cycle that:
- an accepted write raises `busy` for exactly one cycle;
- bank writes happen only in that cycle, and each parity write comes with exactly one data-bank write;
- each output holds whenever its port made no read.

Only the bench's scenarios can show that the words come back correct. That covers the rebuilt word in same-bank conflicts, parity staying consistent across repeated writes to one row, writes issued during `busy` being dropped, and reads right after a write seeing the new data. The bench checks all of these against a flat reference array.

// File: rtl/xm_pkg.sv
package xm_pkg;
    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WR_MERGE = 1'b1
    } xm_state_e;

    localparam int BANK_LO  = 0;
    localparam int BANK_HI  = 1;
    localparam int BANK_PAR = 2;
    localparam int NUM_BANKS = 3;
endpackage

// File: rtl/xm_bank.sv
module xm_bank #(
    parameter int DATA_W = 64,
    parameter int ROW_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  filled;

    // A row that has never been written reads as zero, so all banks start
    // consistent with each other.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
            rdata  <= '0;
        end else if (en) begin
            if (we) begin
                filled[row] <= 1'b1;
            end else begin
                rdata <= filled[row] ? mem[row] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end
    end
endmodule

// File: rtl/xm_ctrl.sv
module xm_ctrl
    import xm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 10,
    localparam int ROW_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ro_addr,
    input  logic [DATA_W-1:0] bank_rdata [NUM_BANKS],
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [ROW_W-1:0]  bank_row [NUM_BANKS],
    output logic [DATA_W-1:0] bank_wdata [NUM_BANKS],
    output logic              busy,
    output logic              p1_vld,
    output logic              p1_bank,
    output logic              p2_vld,
    output logic              p2_bank,
    output logic              p2_rebuild
);
    xm_state_e state, state_nxt;

    logic              wr_bank_q;
    logic [ROW_W-1:0]  wr_row_q;
    logic [DATA_W-1:0] wr_data_q;

    logic             wr_req, rd1_req, rd2_req, conflict, idle;
    logic             b1, b2;
    logic [ROW_W-1:0] row1, row2;

    assign idle     = (state == ST_IDLE);
    assign b1       = rw_addr[ADDR_W-1];
    assign b2       = ro_addr[ADDR_W-1];
    assign row1     = rw_addr[ROW_W-1:0];
    assign row2     = ro_addr[ROW_W-1:0];
    assign wr_req   = !cs_n && we;
    assign rd1_req  = !cs_n && !we;
    assign rd2_req  = rd_en && !wr_req;
    assign conflict = rd1_req && rd2_req && (b1 == b2);
    assign busy     = !idle;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wr_bank_q  <= 1'b0;
            wr_row_q   <= '0;
            wr_data_q  <= '0;
            p1_vld     <= 1'b0;
            p1_bank    <= 1'b0;
            p2_vld     <= 1'b0;
            p2_bank    <= 1'b0;
            p2_rebuild <= 1'b0;
        end else begin
            state      <= state_nxt;
            p1_vld     <= idle && rd1_req;
            p2_vld     <= idle && rd2_req;
            p1_bank    <= b1;
            p2_bank    <= b2;
            p2_rebuild <= conflict;
            if (idle && wr_req) begin
                wr_bank_q <= b1;
                wr_row_q  <= row1;
                wr_data_q <= wdata;
            end
        end
    end

    // Next state and bank commands
    always_comb begin
        state_nxt = state;
        bank_en   = '0;
        bank_we   = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            bank_row[i]   = '0;
            bank_wdata[i] = '0;
        end
        unique case (state)
            ST_IDLE: begin
                if (wr_req) begin
                    // Fetch the partner word at the target row
                    bank_en[b1 ? BANK_LO : BANK_HI]  = 1'b1;
                    bank_row[b1 ? BANK_LO : BANK_HI] = row1;
                    state_nxt = ST_WR_MERGE;
                end else begin
                    if (rd1_req) begin
                        bank_en[b1 ? BANK_HI : BANK_LO]  = 1'b1;
                        bank_row[b1 ? BANK_HI : BANK_LO] = row1;
                    end
                    if (rd2_req) begin
                        if (conflict) begin
                            bank_en[b2 ? BANK_LO : BANK_HI]  = 1'b1;
                            bank_row[b2 ? BANK_LO : BANK_HI] = row2;
                            bank_en[BANK_PAR]  = 1'b1;
                            bank_row[BANK_PAR] = row2;
                        end else begin
                            bank_en[b2 ? BANK_HI : BANK_LO]  = 1'b1;
                            bank_row[b2 ? BANK_HI : BANK_LO] = row2;
                        end
                    end
                end
            end
            ST_WR_MERGE: begin
                bank_en[wr_bank_q ? BANK_HI : BANK_LO]    = 1'b1;
                bank_we[wr_bank_q ? BANK_HI : BANK_LO]    = 1'b1;
                bank_row[wr_bank_q ? BANK_HI : BANK_LO]   = wr_row_q;
                bank_wdata[wr_bank_q ? BANK_HI : BANK_LO] = wr_data_q;
                bank_en[BANK_PAR]    = 1'b1;
                bank_we[BANK_PAR]    = 1'b1;
                bank_row[BANK_PAR]   = wr_row_q;
                bank_wdata[BANK_PAR] = wr_data_q ^ bank_rdata[wr_bank_q ? BANK_LO : BANK_HI];
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/xm_rdmux.sv
module xm_rdmux
    import xm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] bank_rdata [NUM_BANKS],
    input  logic              p1_vld,
    input  logic              p1_bank,
    input  logic              p2_vld,
    input  logic              p2_bank,
    input  logic              p2_rebuild,
    input  logic [DATA_W-1:0] q1_hold,
    input  logic [DATA_W-1:0] q2_hold,
    output logic [DATA_W-1:0] q1,
    output logic [DATA_W-1:0] q2
);
    logic [DATA_W-1:0] direct1, direct2, rebuilt2;

    assign direct1  = p1_bank ? bank_rdata[BANK_HI] : bank_rdata[BANK_LO];
    assign direct2  = p2_bank ? bank_rdata[BANK_HI] : bank_rdata[BANK_LO];
    assign rebuilt2 = (p2_bank ? bank_rdata[BANK_LO] : bank_rdata[BANK_HI])
                      ^ bank_rdata[BANK_PAR];

    assign q1 = p1_vld ? direct1 : q1_hold;
    assign q2 = p2_vld ? (p2_rebuild ? rebuilt2 : direct2) : q2_hold;
endmodule

// File: rtl/xor2r1w_mem.sv
module xor2r1w_mem
    import xm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ro_addr,
    output logic [DATA_W-1:0] q1,
    output logic [DATA_W-1:0] q2,
    output logic              busy
);
    localparam int ROW_W = ADDR_W - 1;

    logic [NUM_BANKS-1:0] bank_en;
    logic [NUM_BANKS-1:0] bank_we;
    logic [ROW_W-1:0]     bank_row   [NUM_BANKS];
    logic [DATA_W-1:0]    bank_wdata [NUM_BANKS];
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    logic p1_vld, p1_bank, p2_vld, p2_bank, p2_rebuild;
    logic [DATA_W-1:0] q1_hold, q2_hold;

    xm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .we         (we),
        .rw_addr    (rw_addr),
        .wdata      (wdata),
        .rd_en      (rd_en),
        .ro_addr    (ro_addr),
        .bank_rdata (bank_rdata),
        .bank_en    (bank_en),
        .bank_we    (bank_we),
        .bank_row   (bank_row),
        .bank_wdata (bank_wdata),
        .busy       (busy),
        .p1_vld     (p1_vld),
        .p1_bank    (p1_bank),
        .p2_vld     (p2_vld),
        .p2_bank    (p2_bank),
        .p2_rebuild (p2_rebuild)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        xm_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[g]),
            .we    (bank_we[g]),
            .row   (bank_row[g]),
            .wdata (bank_wdata[g]),
            .rdata (bank_rdata[g])
        );
    end

    xm_rdmux #(.DATA_W(DATA_W)) rdmux_i (
        .bank_rdata (bank_rdata),
        .p1_vld     (p1_vld),
        .p1_bank    (p1_bank),
        .p2_vld     (p2_vld),
        .p2_bank    (p2_bank),
        .p2_rebuild (p2_rebuild),
        .q1_hold    (q1_hold),
        .q2_hold    (q2_hold),
        .q1         (q1),
        .q2         (q2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1_hold <= '0;
            q2_hold <= '0;
        end else begin
            q1_hold <= q1;
            q2_hold <= q2;
        end
    end
endmodule

// File: rtl/xm_checker.sv
module xm_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we,
    input logic              rd_en,
    input logic [DATA_W-1:0] q1,
    input logic [DATA_W-1:0] q2,
    input logic              busy,
    input logic [2:0]        bank_we
);
    a_r6_write_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && we) |=> busy);

    a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r6_no_store_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bank_we == 3'b000));

    a_r9_parity_pairs_data: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bank_we[2] && $countones(bank_we[1:0]) == 1));

    a_r8_q1_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || cs_n || we) |=> $stable(q1));

    a_r8_q2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !rd_en || (!cs_n && we)) |=> $stable(q2));
endmodule

bind xor2r1w_mem xm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we      (we),
    .rd_en   (rd_en),
    .q1      (q1),
    .q2      (q2),
    .busy    (busy),
    .bank_we (bank_we)
);

// File: tb/xor2r1w_mem_tb_top.sv
`timescale 1ns/1ps
module xor2r1w_mem_tb_top;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 10;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int HALF   = WORDS / 2;
    localparam int WD_CYCLES = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] rw_addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] ro_addr = '0;
    logic [DATA_W-1:0] q1, q2;
    logic              busy;

    logic [DATA_W-1:0] gold_mem [WORDS];
    logic [DATA_W-1:0] exp_q1 = '0, exp_q2 = '0;
    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    xor2r1w_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we(we), .rw_addr(rw_addr),
        .wdata(wdata), .rd_en(rd_en), .ro_addr(ro_addr),
        .q1(q1), .q2(q2), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_idle();
        cs_n = 1'b1; we = 1'b0; rd_en = 1'b0;
    endtask

    // Read on chosen ports; starts and ends at a negative edge
    task automatic do_read(input logic [ADDR_W-1:0] a1, input bit e1,
                           input logic [ADDR_W-1:0] a2, input bit e2, input string req);
        cs_n = !e1; we = 1'b0; rw_addr = a1;
        rd_en = e2; ro_addr = a2;
        @(posedge clk);
        @(negedge clk);
        if (e1) exp_q1 = gold_mem[a1];
        if (e2) exp_q2 = gold_mem[a2];
        check(q1 === exp_q1, {req, " q1"}, q1, exp_q1);
        check(q2 === exp_q2, {req, " q2"}, q2, exp_q2);
        drive_idle();
    endtask

    // Write; optionally drives a competing request during the busy cycle
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input bit noise, input logic [ADDR_W-1:0] na);
        cs_n = 1'b0; we = 1'b1; rw_addr = a; wdata = d;
        rd_en = 1'b1; ro_addr = ~a;
        @(posedge clk);
        @(negedge clk);
        check(busy === 1'b1, "R6 busy after write", {63'd0, busy}, 64'd1);
        check(q1 === exp_q1 && q2 === exp_q2, "R7 outputs hold in write", q1 ^ q2, exp_q1 ^ exp_q2);
        if (noise) begin
            cs_n = 1'b0; we = 1'b1; rw_addr = na; wdata = ~d;
            rd_en = 1'b1; ro_addr = na;
        end else begin
            drive_idle();
        end
        @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0, "R6 busy one cycle", {63'd0, busy}, 64'd0);
        check(q1 === exp_q1 && q2 === exp_q2, "R7 outputs hold in merge", q1 ^ q2, exp_q1 ^ exp_q2);
        gold_mem[a] = d;
        drive_idle();
    endtask

    task automatic t_reset();
        check(q1 === '0, "R1 q1 reset", q1, '0);
        check(q2 === '0, "R1 q2 reset", q2, '0);
        check(busy === 1'b0, "R1 busy reset", {63'd0, busy}, 64'd0);
        do_read(10'd0, 1'b1, 10'(WORDS - 1), 1'b1, "R1 unwritten");
    endtask

    task automatic t_map();
        do_write(10'd5, 64'hAAAA_0000_0000_0005, 1'b0, '0);
        do_write(10'(HALF + 5), 64'hBBBB_0000_0000_0205, 1'b0, '0);
        do_read(10'd5, 1'b1, 10'(HALF + 5), 1'b1, "R2 R4 split banks");
        do_read(10'(HALF + 5), 1'b1, 10'd5, 1'b1, "R4 split swapped");
    endtask

    task automatic t_conflict();
        do_write(10'd10, 64'h1111_2222_3333_4444, 1'b0, '0);
        do_write(10'd20, 64'h5555_6666_7777_8888, 1'b0, '0);
        do_write(10'(HALF + 20), 64'h9999_AAAA_BBBB_CCCC, 1'b0, '0);
        do_read(10'd10, 1'b1, 10'd20, 1'b1, "R5 low bank conflict");
        do_read(10'(HALF + 10), 1'b1, 10'(HALF + 20), 1'b1, "R5 high bank conflict");
        do_read(10'd20, 1'b1, 10'd20, 1'b1, "R5 same address");
        do_read(10'd10, 1'b1, 10'd10, 1'b1, "R5 same address row zero partner");
    endtask

    task automatic t_busy_ignore();
        do_write(10'd40, 64'hDEAD_BEEF_0000_0040, 1'b1, 10'd41);
        do_read(10'd41, 1'b1, 10'd40, 1'b1, "R6 write during busy ignored");
    endtask

    task automatic t_hold();
        do_read(10'd0, 1'b0, 10'd20, 1'b1, "R11 ro port alone");
        do_read(10'(HALF + 5), 1'b1, 10'd0, 1'b0, "R8 q2 holds");
        @(posedge clk); @(negedge clk);
        check(q1 === exp_q1 && q2 === exp_q2, "R8 idle hold", q1 ^ q2, exp_q1 ^ exp_q2);
    endtask

    task automatic t_same_row();
        do_write(10'd33, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, '0);
        do_write(10'(HALF + 33), 64'hF0F0_1234_F0F0_5678, 1'b0, '0);
        do_write(10'd33, 64'h0123_4567_89AB_CDEF, 1'b0, '0);
        do_read(10'd33, 1'b1, 10'd33, 1'b1, "R9 low row rebuild");
        do_read(10'(HALF + 33), 1'b1, 10'(HALF + 33), 1'b1, "R9 high row rebuild");
        do_read(10'd34, 1'b1, 10'd33, 1'b1, "R9 rebuild from other row");
    endtask

    task automatic t_after_write();
        do_write(10'd77, 64'hCAFE_0000_0000_0077, 1'b0, '0);
        do_read(10'd77, 1'b1, 10'd77, 1'b1, "R10 read right after write");
        do_write(10'(HALF + 77), 64'hCAFE_1111_0000_0277, 1'b0, '0);
        do_read(10'd77, 1'b1, 10'(HALF + 77), 1'b1, "R10 R3 read after second write");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 600; i++) begin
            logic [ADDR_W-1:0] a1, a2;
            seed = seed * 32'd1103515245 + 32'd12345;
            a1 = {seed[20], 6'd0, seed[18:16]};
            a2 = {seed[24], 6'd0, seed[23:21]};
            if (seed[30:29] == 2'b00) begin
                do_write(a1, {seed, ~seed}, seed[27], a2);
            end else begin
                do_read(a1, seed[28] | seed[26], a2, seed[27] | seed[25], "R4 R5 mixed");
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(WD_CYCLES * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) gold_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_conflict();
        t_busy_ignore();
        t_hold();
        t_same_row();
        t_after_write();
        t_mixed();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule